// File: doc/BRIEF.md
# Matrix Scroll Sequencer

This block drives the scrolling of an image on a dot-matrix LED display. Software programs an axis and sense of motion, a step interval, a step count and a page mode, then issues a launch command. From then on the sequencer moves the picture by one dot every interval. For each step it gives the scan logic a signed offset along the chosen axis and tells it which of the two stored frames fills the rows or columns that come into view. When the programmed number of steps is reached the image stops where it is and a sticky completion flag is raised.

The block takes a one-millisecond tick and a geometry input that chooses between the full 17-column by 7-row layout and the reduced 15 by 5 layout. The geometry is captured at launch. The interrupt line merges the scroll flag with two completion flags from neighbouring fade engines. Fetching pixels and multiplexing the matrix are done elsewhere.

Software reaches the block through a small write port with three registers. SETUP (address 0) holds direction in bits [1:0], page mode in bit 2, enable in bit 3 and speed in bits [7:4]. LAUNCH (address 1) holds the count in bits [5:0] and a launch strobe in bit 7. ACK (address 2) holds a flag-clear strobe in bit 0. Both strobes act only in the cycle they are written and leave nothing behind.

Top module: `mscroll_seq`

## Requirements
- R1: Direction code 00 moves right and 11 moves down, and both give a positive offset. Code 01 moves left and 10 moves up, and both give a negative offset. `shift_vert` is high while a scroll is active or held on the up/down axis (code bit 1 set).
- R2: A step happens every 50 × (speed + 1) millisecond ticks, counted from the launch, so the interval runs from 50 to 800 ticks.
- R3: A count above the legal range is clamped to twice the page length on the active axis. That gives 34 horizontal and 14 vertical steps in the 17×7 layout, and 30 and 10 steps in the 15×5 layout (`narrow_mode` = 1).
- R4: A count of 0 runs exactly one page length of steps: 17, 7, 15 or 5 depending on axis and layout.
- R5: A launch starts a scroll only if the enable bit is already set when the launch takes effect. A launch while disabled is ignored, and setting enable afterwards does not start it.
- R6: With page mode 0, both frame outputs follow `page_sel`. With page mode 1, `base_frame` is `page_sel` XOR the wrap parity and `fill_frame` is its complement. The wrap parity toggles every time the offset wraps through a full page.
- R7: After the last step the offset and frames hold with no further change. Clearing enable returns the offset to 0 and both frames to `page_sel` two clock cycles after the SETUP write.
- R8: Completion sets `scroll_flag`, and the flag stays set through further ticks. Writing ACK with bit 0 set clears it. Writing ACK with bit 0 clear leaves it set.
- R9: `irq` is high whenever any of `scroll_flag`, `fade_flag` or `pal_flag` is high.
- R10: The offset magnitude is the number of steps taken modulo the page length, so after a full page it wraps back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| narrow_mode | input | 1 | 0 = 17×7 layout, 1 = 15×5 layout |
| page_sel | input | 1 | Programmed display frame |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 SETUP, 1 LAUNCH, 2 ACK) |
| wr_data | input | 8 | Register write data |
| fade_flag | input | 1 | Whole-display fade completion flag |
| pal_flag | input | 1 | Palette fade completion flag |
| shift_ofs | output | 6 | Signed scroll offset in dots |
| shift_vert | output | 1 | Offset applies to rows rather than columns |
| base_frame | output | 1 | Frame shown in the unshifted region |
| fill_frame | output | 1 | Frame for dots shifted into view |
| scroll_flag | output | 1 | Sticky end-of-scroll flag |
| irq | output | 1 | Combined interrupt |

## Verification
The bench aims at the count boundaries: a zero count, counts beyond the clamp in both layouts and on both axes, and counts that wrap more than one page. A design that mixes up the per-mode limits, or treats zero as zero steps, stops after the wrong number of ticks or with a non-zero offset. A launch issued while disabled, followed by enabling, catches a design that remembers the launch. Alternate-page runs that end past one wrap expose an inverted or missing parity in the frame outputs. A tick-exact interval count at the slowest speed catches an off-by-one in the divider, and a hold phase with extra ticks catches a sequencer that keeps running after completion.

// File: rtl/mscroll_pkg.sv
package mscroll_pkg;

    localparam int SPEED_W = 4;
    localparam int CNT_W   = 6;
    localparam int STEP_W  = 8;

    localparam logic [1:0] REG_SETUP  = 2'd0;
    localparam logic [1:0] REG_LAUNCH = 2'd1;
    localparam logic [1:0] REG_ACK    = 2'd2;

    typedef enum logic [1:0] {
        DIR_RIGHT = 2'b00,
        DIR_LEFT  = 2'b01,
        DIR_UP    = 2'b10,
        DIR_DOWN  = 2'b11
    } scroll_dir_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } scroll_state_e;

    typedef struct packed {
        logic [SPEED_W-1:0] speed;
        logic               enable;
        logic               alt_page;
        scroll_dir_e        dir;
    } setup_t;

    function automatic logic [STEP_W-1:0] page_len(
        input logic vert, input logic narrow,
        input int cols, input int rows, input int ncols, input int nrows);
        if (vert) return narrow ? STEP_W'(nrows) : STEP_W'(rows);
        return narrow ? STEP_W'(ncols) : STEP_W'(cols);
    endfunction

    function automatic logic [STEP_W-1:0] run_target(
        input logic [CNT_W-1:0] cnt, input logic [STEP_W-1:0] len);
        logic [STEP_W:0] cap;
        cap = {len, 1'b0};
        if (cnt == '0) return len;
        if ({{(STEP_W+1-CNT_W){1'b0}}, cnt} > cap) return cap[STEP_W-1:0];
        return {{(STEP_W-CNT_W){1'b0}}, cnt};
    endfunction

endpackage

// File: rtl/mscroll_regs.sv
module mscroll_regs
    import mscroll_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [7:0]         wr_data,
    input  logic               done_evt,
    output setup_t             setup,
    output logic [CNT_W-1:0]   count_q,
    output logic               go_q,
    output logic               clr_req,
    output logic               flag
);
    logic go_req;

    assign go_req  = wr_en && (wr_addr == REG_LAUNCH) && wr_data[7];
    assign clr_req = wr_en && (wr_addr == REG_ACK) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            setup   <= '0;
            count_q <= '0;
            go_q    <= 1'b0;
        end else begin
            go_q <= go_req;
            if (wr_en && wr_addr == REG_SETUP)
                setup <= setup_t'(wr_data);
            if (wr_en && wr_addr == REG_LAUNCH)
                count_q <= wr_data[CNT_W-1:0];
        end
    end

    // completion wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (done_evt) flag <= 1'b1;
        else if (clr_req)  flag <= 1'b0;
    end
endmodule

// File: rtl/mscroll_pace.sv
module mscroll_pace
    import mscroll_pkg::*;
#(
    parameter int UNIT_TICKS = 50
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               run,
    input  logic               tick,
    input  logic [SPEED_W-1:0] speed,
    output logic               fire
);
    localparam int LIM_MAX = UNIT_TICKS * (2 ** SPEED_W);
    localparam int CW      = $clog2(LIM_MAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = CW'(UNIT_TICKS * (int'(speed) + 1));
    assign fire = run && tick && !clear && (cnt == lim - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || clear)     cnt <= '0;
        else if (run && tick) cnt <= (cnt == lim - CW'(1)) ? '0 : cnt + CW'(1);
    end
endmodule

// File: rtl/mscroll_walk.sv
module mscroll_walk
    import mscroll_pkg::*;
#(
    parameter int COLS  = 17,
    parameter int ROWS  = 7,
    parameter int NCOLS = 15,
    parameter int NROWS = 5,
    localparam int POS_W = $clog2(COLS)
) (
    input  logic               clk,
    input  logic               rst,
    input  setup_t             cfg,
    input  logic [CNT_W-1:0]   count_q,
    input  logic               go_q,
    input  logic               narrow,
    input  logic               fire,
    output logic               running,
    output logic               idle,
    output logic [POS_W-1:0]   pos,
    output logic               par,
    output scroll_dir_e        dir_l,
    output logic               alt_l,
    output logic [SPEED_W-1:0] spd_l,
    output logic               done_evt
);
    scroll_state_e     state;
    logic [STEP_W-1:0] len, tgt, steps, new_len;
    logic              adv, wrap;

    assign new_len  = page_len(cfg.dir[1], narrow, COLS, ROWS, NCOLS, NROWS);
    assign running  = (state == ST_RUN);
    assign idle     = (state == ST_IDLE);
    assign adv      = running && fire && cfg.enable && !go_q;
    assign wrap     = ({{(STEP_W-POS_W){1'b0}}, pos} == len - STEP_W'(1));
    assign done_evt = adv && (steps + STEP_W'(1) == tgt);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pos   <= '0;
            par   <= 1'b0;
            steps <= '0;
            len   <= '0;
            tgt   <= '0;
            dir_l <= DIR_RIGHT;
            alt_l <= 1'b0;
            spd_l <= '0;
        end else if (!cfg.enable) begin
            state <= ST_IDLE;
            pos   <= '0;
            par   <= 1'b0;
            steps <= '0;
        end else if (go_q) begin
            state <= ST_RUN;
            pos   <= '0;
            par   <= 1'b0;
            steps <= '0;
            len   <= new_len;
            tgt   <= run_target(count_q, new_len);
            dir_l <= cfg.dir;
            alt_l <= cfg.alt_page;
            spd_l <= cfg.speed;
        end else if (adv) begin
            steps <= steps + STEP_W'(1);
            pos   <= wrap ? '0 : pos + POS_W'(1);
            par   <= par ^ wrap;
            if (done_evt) state <= ST_HOLD;
        end
    end
endmodule

// File: rtl/mscroll_seq.sv
module mscroll_seq
    import mscroll_pkg::*;
#(
    parameter int COLS       = 17,
    parameter int ROWS       = 7,
    parameter int NCOLS      = 15,
    parameter int NROWS      = 5,
    parameter int UNIT_TICKS = 50,
    localparam int POS_W     = $clog2(COLS),
    localparam int OFS_W     = POS_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ms_tick,
    input  logic                    narrow_mode,
    input  logic                    page_sel,
    input  logic                    wr_en,
    input  logic [1:0]              wr_addr,
    input  logic [7:0]              wr_data,
    input  logic                    fade_flag,
    input  logic                    pal_flag,
    output logic signed [OFS_W-1:0] shift_ofs,
    output logic                    shift_vert,
    output logic                    base_frame,
    output logic                    fill_frame,
    output logic                    scroll_flag,
    output logic                    irq
);
    setup_t             cfg;
    logic [CNT_W-1:0]   count_q;
    logic               go_q, clr_req, done_evt, fire;
    logic               running, idle, par, alt_l;
    logic [POS_W-1:0]   pos;
    scroll_dir_e        dir_l;
    logic [SPEED_W-1:0] spd_l;
    logic               cfg_en;
    logic [OFS_W-1:0]   mag;
    logic               neg, paged;

    mscroll_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done_evt(done_evt), .setup(cfg), .count_q(count_q), .go_q(go_q),
        .clr_req(clr_req), .flag(scroll_flag)
    );

    mscroll_pace #(.UNIT_TICKS(UNIT_TICKS)) u_pace (
        .clk(clk), .rst(rst), .clear(go_q || !cfg.enable), .run(running),
        .tick(ms_tick), .speed(spd_l), .fire(fire)
    );

    mscroll_walk #(.COLS(COLS), .ROWS(ROWS), .NCOLS(NCOLS), .NROWS(NROWS)) u_walk (
        .clk(clk), .rst(rst), .cfg(cfg), .count_q(count_q), .go_q(go_q),
        .narrow(narrow_mode), .fire(fire), .running(running), .idle(idle),
        .pos(pos), .par(par), .dir_l(dir_l), .alt_l(alt_l), .spd_l(spd_l),
        .done_evt(done_evt)
    );

    assign cfg_en     = cfg.enable;
    assign mag        = {1'b0, pos};
    assign neg        = (dir_l == DIR_LEFT) || (dir_l == DIR_UP);
    assign shift_ofs  = idle ? '0 : (neg ? -mag : mag);
    assign shift_vert = !idle && dir_l[1];
    assign paged      = !idle && alt_l;
    assign base_frame = paged ? (page_sel ^ par) : page_sel;
    assign fill_frame = paged ? (page_sel ^ ~par) : page_sel;
    assign irq        = scroll_flag | fade_flag | pal_flag;
endmodule

// File: rtl/mscroll_seq_chk.sv
module mscroll_seq_chk #(
    parameter int OFS_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             ms_tick,
    input logic             cfg_en,
    input logic             go_q,
    input logic [OFS_W-1:0] shift_ofs,
    input logic             scroll_flag,
    input logic             clr_req,
    input logic             fade_flag,
    input logic             pal_flag,
    input logic             irq
);
    assert_disable_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> (shift_ofs == '0));

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (!ms_tick && cfg_en && !go_q) |=> $stable(shift_ofs));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (scroll_flag && !clr_req) |=> scroll_flag);

    assert_flag_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(scroll_flag) |-> $past(ms_tick));

    assert_irq_fade_R9: assert property (@(posedge clk) disable iff (rst)
        (fade_flag || pal_flag) |-> irq);
endmodule

bind mscroll_seq mscroll_seq_chk #(.OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .cfg_en(cfg_en), .go_q(go_q),
    .shift_ofs(shift_ofs), .scroll_flag(scroll_flag), .clr_req(clr_req),
    .fade_flag(fade_flag), .pal_flag(pal_flag), .irq(irq)
);

// File: tb/mscroll_seq_test.sv
module mscroll_seq_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ms_tick = 0, narrow_mode = 0, page_sel = 0, wr_en = 0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic fade_flag = 0, pal_flag = 0;
    logic signed [5:0] shift_ofs;
    logic shift_vert, base_frame, fill_frame, scroll_flag, irq;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mscroll_seq uut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .narrow_mode(narrow_mode),
        .page_sel(page_sel), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fade_flag(fade_flag), .pal_flag(pal_flag), .shift_ofs(shift_ofs),
        .shift_vert(shift_vert), .base_frame(base_frame), .fill_frame(fill_frame),
        .scroll_flag(scroll_flag), .irq(irq)
    );

    // behavioural reference model
    int m_en, m_dir, m_alt, m_spd, m_cnt, m_goq, m_flag;
    int m_state, m_len, m_tgt, m_int, m_t, m_pos, m_par, m_steps;

    always @(posedge clk) begin
        int ev;
        ev = 0;
        if (rst) begin
            m_en = 0; m_dir = 0; m_alt = 0; m_spd = 0; m_cnt = 0; m_goq = 0; m_flag = 0;
            m_state = 0; m_len = 0; m_tgt = 0; m_int = 50; m_t = 0; m_pos = 0; m_par = 0; m_steps = 0;
        end else begin
            if (m_en == 0) begin
                m_state = 0; m_pos = 0; m_par = 0; m_t = 0; m_steps = 0;
            end else if (m_goq != 0) begin
                m_state = 1; m_pos = 0; m_par = 0; m_t = 0; m_steps = 0;
                if (m_dir >= 2) m_len = narrow_mode ? 5 : 7;
                else            m_len = narrow_mode ? 15 : 17;
                if (m_cnt == 0) m_tgt = m_len;
                else if (m_cnt > 2 * m_len) m_tgt = 2 * m_len;
                else m_tgt = m_cnt;
                m_alt = m_alt; m_int = 50 * (m_spd + 1);
                m_ldir = m_dir; m_lalt = m_alt;
            end else if (m_state == 1 && ms_tick) begin
                if (m_t == m_int - 1) begin
                    m_t = 0;
                    m_steps++;
                    if (m_pos == m_len - 1) begin m_pos = 0; m_par ^= 1; end
                    else m_pos++;
                    if (m_steps == m_tgt) begin m_state = 2; ev = 1; end
                end else m_t++;
            end
            if (ev) m_flag = 1;
            else if (wr_en && wr_addr == 2 && wr_data[0]) m_flag = 0;
            m_goq = (wr_en && wr_addr == 1 && wr_data[7]) ? 1 : 0;
            if (wr_en && wr_addr == 1) m_cnt = wr_data[5:0];
            if (wr_en && wr_addr == 0) begin
                m_dir = wr_data[1:0]; m_alt = wr_data[2]; m_en = wr_data[3]; m_spd = wr_data[7:4];
            end
        end
    end
    int m_ldir = 0, m_lalt = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int e_ofs, e_base, e_fill;
        if (!rst && !finished) begin
            if (m_state == 0) e_ofs = 0;
            else e_ofs = (m_ldir == 1 || m_ldir == 2) ? -m_pos : m_pos;
            if (m_state != 0 && m_lalt != 0) begin
                e_base = page_sel ^ m_par; e_fill = page_sel ^ (1 - m_par);
            end else begin
                e_base = page_sel; e_fill = page_sel;
            end
            chk("R1 offset", int'(shift_ofs), e_ofs);
            chk("R1 axis", int'(shift_vert), (m_state != 0 && m_ldir >= 2) ? 1 : 0);
            chk("R6 base frame", int'(base_frame), e_base);
            chk("R6 fill frame", int'(fill_frame), e_fill);
            chk("R8 flag", int'(scroll_flag), m_flag);
            chk("R9 irq", int'(irq), (m_flag != 0 || fade_flag || pal_flag) ? 1 : 0);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_data = '0;
    endtask

    task automatic tick1();
        ms_tick = 1;
        @(negedge clk);
        ms_tick = 0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick1();
    endtask

    // launch and count ticks until the flag appears
    task automatic scroll_run(input logic [1:0] dir, input logic alt, input logic [3:0] spd,
                              input logic [5:0] cnt, input logic nar, input int exp_steps,
                              input string tag);
        int n;
        narrow_mode = nar;
        wr(2'd2, 8'h01);
        wr(2'd0, {spd, 1'b1, alt, dir});
        wr(2'd1, {2'b10, cnt});
        @(negedge clk);
        n = 0;
        while (!scroll_flag && n < 5000) begin tick1(); n++; end
        chk(tag, n, exp_steps * 50 * (int'(spd) + 1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("reset offset R1", int'(shift_ofs), 0);
        chk("reset flag R8", int'(scroll_flag), 0);
        chk("reset frame R6", int'(fill_frame), 0);

        // R5: launch while disabled, then enable
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h81);
        @(negedge clk);
        ticks(60);
        chk("R5 disabled launch offset", int'(shift_ofs), 0);
        wr(2'd0, 8'h08);
        ticks(60);
        chk("R5 late enable offset", int'(shift_ofs), 0);
        chk("R5 late enable flag", int'(scroll_flag), 0);

        // R2 interval, R1 right sign, R7 hold, R8 clear
        scroll_run(2'b00, 0, 4'd0, 6'd3, 0, 3, "R2 ticks speed0");
        chk("R1 right offset", int'(shift_ofs), 3);
        ticks(120);
        chk("R7 held offset", int'(shift_ofs), 3);
        chk("R8 flag sticky", int'(scroll_flag), 1);
        wr(2'd2, 8'h00);
        chk("R8 zero ack keeps flag", int'(scroll_flag), 1);
        wr(2'd2, 8'h01);
        chk("R8 flag cleared", int'(scroll_flag), 0);
        wr(2'd0, 8'h00);
        @(negedge clk);
        chk("R7 disable offset", int'(shift_ofs), 0);

        scroll_run(2'b01, 0, 4'd1, 6'd2, 0, 2, "R2 ticks speed1");
        chk("R1 left offset", int'(shift_ofs), -2);
        scroll_run(2'b00, 0, 4'd15, 6'd1, 1, 1, "R2 ticks speed15");
        chk("R1 right narrow", int'(shift_ofs), 1);

        scroll_run(2'b10, 0, 4'd0, 6'd0, 0, 7, "R4 zero count vertical");
        chk("R4 page wrap offset", int'(shift_ofs), 0);
        chk("R1 vertical axis", int'(shift_vert), 1);
        scroll_run(2'b01, 0, 4'd0, 6'd0, 1, 15, "R4 zero count narrow horiz");
        scroll_run(2'b11, 0, 4'd0, 6'd9, 0, 9, "R10 down nine");
        chk("R10 wrapped offset", int'(shift_ofs), 2);

        scroll_run(2'b00, 0, 4'd0, 6'd40, 0, 34, "R3 clamp full horiz");
        scroll_run(2'b10, 0, 4'd0, 6'd20, 0, 14, "R3 clamp full vert");
        scroll_run(2'b01, 0, 4'd0, 6'd50, 1, 30, "R3 clamp narrow horiz");
        scroll_run(2'b11, 0, 4'd0, 6'd63, 1, 10, "R3 clamp narrow vert");

        page_sel = 1;
        scroll_run(2'b00, 1, 4'd0, 6'd20, 0, 20, "R6 alt run steps");
        chk("R6 alt base", int'(base_frame), 0);
        chk("R6 alt fill", int'(fill_frame), 1);
        chk("R10 alt offset", int'(shift_ofs), 3);
        wr(2'd0, 8'h00);
        @(negedge clk);
        chk("R7 frame returns", int'(base_frame), 1);
        scroll_run(2'b00, 0, 4'd0, 6'd20, 0, 20, "R6 single run steps");
        chk("R6 single base", int'(base_frame), 1);
        chk("R6 single fill", int'(fill_frame), 1);

        wr(2'd2, 8'h01);
        fade_flag = 1;
        @(negedge clk);
        chk("R9 fade irq", int'(irq), 1);
        fade_flag = 0; pal_flag = 1;
        @(negedge clk);
        chk("R9 palette irq", int'(irq), 1);
        pal_flag = 0;
        @(negedge clk);
        chk("R9 quiet irq", int'(irq), 0);

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule